// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block carries out the stack side of subroutine linkage for a small processor. It handles calls, returns, returns from interrupt and single-byte push/pop against a byte-wide data memory, using a 16-bit stack pointer that grows downward. Decode logic presents one request together with the current word program counter, a target field, the 16-bit Z pointer and an extension byte. The sequencer then moves one byte per clock across the memory port. When it finishes, it pulses `done` and presents the new program counter, the new stack pointer and any popped byte.

A configuration input selects either two-byte or three-byte return addresses. Every new program counter value is limited to the implemented program space, which is 64K words by default. The memory read path is combinational: `mem_rdata` must reflect `mem_addr` in the same cycle that `mem_re` is high.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp_out` equals SP_RESET (0x08FF by default), `pc_out` is 0, and `mem_we`, `mem_re`, `done` and `set_ie` are all low.
- R2: A push (req_op 6) writes `ext_in` at the address held in the stack pointer and then decrements the pointer by one. The write occupies one cycle.
- R3: A pop (req_op 7) first increments the stack pointer and then reads the byte at the incremented address. That byte appears on `pop_data` while `done` is high.
- R4: A call writes the return address one byte per cycle: bits 7:0 first, then bits 15:8, then bits 23:16 only when `wide_pc` is 1. Each write uses the post-decrement rule of R2.
- R5: A return (req_op 4) reads bytes using the pre-increment rule of R3. It reads bits 23:16 first when `wide_pc` is 1, then bits 15:8, then bits 7:0. The assembled value becomes `pc_out`, and `sp_out` holds the final pointer.
- R6: A return from interrupt (req_op 5) behaves like R5 and also raises `set_ie` for exactly the cycle in which `done` is high.
- R7: A relative call (req_op 1) jumps to pc_in + 1 plus the sign-extended value of target_in[11:0]. Its return address is pc_in + 1.
- R8: An indirect call (req_op 2) jumps to `zptr_in`. The extended indirect call (req_op 3) jumps to {ext_in, zptr_in}. Both return to pc_in + 1.
- R9: A direct call (req_op 0) jumps to `target_in` and stores the return address pc_in + 2.
- R10: Every new `pc_out` value is masked to PC_SPACE bits (16 by default), so all higher bits read as 0.
- R11: A request presented while a sequence is in progress is ignored. It starts no memory access and does not change the outcome of the sequence already running.
- R12: `done` is high for exactly one cycle, immediately after the cycle of the last memory access. `mem_we` and `mem_re` are never high together, and the stack pointer changes only in a cycle that carries a memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_pc | input | 1 | 1 selects three-byte return addresses |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_op | input | 3 | 0 direct call, 1 relative call, 2 indirect, 3 extended indirect, 4 return, 5 return from interrupt, 6 push, 7 pop |
| pc_in | input | PC_W | Word address of the current instruction |
| target_in | input | PC_W | Direct call target; bits 11:0 hold the relative offset |
| zptr_in | input | 16 | Z pointer for indirect calls |
| ext_in | input | 8 | Extension byte for extended indirect calls; data byte for push |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | SP_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_re` |
| sp_out | output | SP_W | Current stack pointer |
| pc_out | output | PC_W | New program counter, valid while `done` is high |
| pop_data | output | 8 | Byte read by the last pop |
| set_ie | output | 1 | Pulse that sets the global interrupt enable flag |
| done | output | 1 | Sequence complete |

## Verification
The assertions assume that the memory returns read data combinationally, and that `wide_pc` is held steady while a sequence is running. The stimulus changes `wide_pc` only between sequences and backs the port with a small array indexed by the low address byte. Stack use stays well below 256 bytes, so no two live stack slots alias in that array. One call is issued with a competing request held high during its transfer; the recorded access stream and the final state must be unchanged.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int PC_W = 22,
  parameter int PC_SPACE = 16,
  parameter int SP_W = 16,
  parameter logic [SP_W-1:0] SP_RESET = 16'h08FF
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_pc,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [PC_W-1:0] pc_in,
  input  logic [PC_W-1:0] target_in,
  input  logic [15:0]     zptr_in,
  input  logic [7:0]      ext_in,
  output logic            mem_we,
  output logic            mem_re,
  output logic [SP_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic [SP_W-1:0] sp_out,
  output logic [PC_W-1:0] pc_out,
  output logic [7:0]      pop_data,
  output logic            set_ie,
  output logic            done
);
  localparam logic [PC_W-1:0] PC_MASK = PC_W'((64'd1 << PC_SPACE) - 64'd1);
  localparam logic [2:0] OP_DIR = 3'd0, OP_REL = 3'd1, OP_IND = 3'd2, OP_EIND = 3'd3,
                         OP_RET = 3'd4, OP_RETI = 3'd5, OP_PUSH = 3'd6, OP_POP = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} st_t;

  st_t             st;
  logic [2:0]      op_q;
  logic [1:0]      cnt;
  logic [23:0]     sh;
  logic [PC_W-1:0] tgt_q, pc_q;
  logic [SP_W-1:0] sp_q;
  logic [7:0]      pop_q;

  logic            accept, req_call, req_push, q_call, q_wr, q_ret;
  logic [PC_W-1:0] seq1, ret_addr, tgt;
  logic [1:0]      last_idx;
  logic [23:0]     assembled;

  assign accept   = req_valid && (st == S_IDLE);
  assign req_call = req_op <= OP_EIND;
  assign req_push = req_op == OP_PUSH;
  assign q_call   = op_q <= OP_EIND;
  assign q_ret    = (op_q == OP_RET) || (op_q == OP_RETI);
  assign q_wr     = q_call || (op_q == OP_PUSH);

  assign seq1     = pc_in + PC_W'(1);
  assign ret_addr = (req_op == OP_DIR) ? pc_in + PC_W'(2) : seq1;
  assign last_idx = (req_op >= OP_PUSH) ? 2'd0 : (wide_pc ? 2'd2 : 2'd1);
  assign assembled = {sh[15:0], mem_rdata};

  always_comb begin
    case (req_op)
      OP_DIR:  tgt = target_in;
      OP_REL:  tgt = seq1 + {{(PC_W-12){target_in[11]}}, target_in[11:0]};
      OP_IND:  tgt = PC_W'(zptr_in);
      OP_EIND: tgt = PC_W'({ext_in, zptr_in});
      default: tgt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= '0;
      cnt   <= '0;
      sh    <= '0;
      tgt_q <= '0;
      pc_q  <= '0;
      sp_q  <= SP_RESET;
      pop_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q  <= req_op;
          cnt   <= last_idx;
          tgt_q <= tgt & PC_MASK;
          sh    <= req_call ? 24'(ret_addr) : (req_push ? {16'd0, ext_in} : 24'd0);
          st    <= S_XFER;
        end
        S_XFER: begin
          if (q_wr) begin
            sp_q <= sp_q - SP_W'(1);
            sh   <= sh >> 8;
          end else begin
            sp_q <= sp_q + SP_W'(1);
            sh   <= assembled;
          end
          if (cnt == 2'd0) begin
            st <= S_FIN;
            if (q_call) pc_q <= tgt_q;
            if (q_ret)  pc_q <= PC_W'(assembled) & PC_MASK;
            if (op_q == OP_POP) pop_q <= mem_rdata;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_we    = (st == S_XFER) && q_wr;
  assign mem_re    = (st == S_XFER) && !q_wr;
  assign mem_addr  = mem_re ? sp_q + SP_W'(1) : sp_q;
  assign mem_wdata = sh[7:0];
  assign sp_out    = sp_q;
  assign pc_out    = pc_q;
  assign pop_data  = pop_q;
  assign done      = st == S_FIN;
  assign set_ie    = done && (op_q == OP_RETI);
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int PC_W = 22,
  parameter int PC_SPACE = 16,
  parameter int SP_W = 16
)(
  input logic            clk,
  input logic            rst_n,
  input logic            mem_we,
  input logic            mem_re,
  input logic [SP_W-1:0] mem_addr,
  input logic [SP_W-1:0] sp_out,
  input logic [PC_W-1:0] pc_out,
  input logic            set_ie,
  input logic            done
);
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_push_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp_out);
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_out == $past(sp_out) - SP_W'(1));
  assert_pop_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr == sp_out + SP_W'(1));
  assert_pop_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_out == $past(sp_out) + SP_W'(1));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_follows_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && !done |=> done || mem_we || mem_re);
  assert_sp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we || mem_re) |=> sp_out == $past(sp_out));
  assert_ie_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_ie |-> done);
  assert_pc_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_out >> PC_SPACE) == '0);
endmodule

bind stack_seq stack_seq_chk #(.PC_W(PC_W), .PC_SPACE(PC_SPACE), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .sp_out(sp_out), .pc_out(pc_out), .set_ie(set_ie), .done(done));

// File: tb/stack_seq_bench.sv
module stack_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, wide_pc = 1'b0, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [21:0] pc_in = '0, target_in = '0;
  logic [15:0] zptr_in = '0;
  logic [7:0] ext_in = '0;
  logic mem_we, mem_re, set_ie, done;
  logic [15:0] mem_addr, sp_out;
  logic [7:0] mem_wdata, mem_rdata, pop_data;
  logic [21:0] pc_out;
  logic [7:0] mem [0:255];
  int checks = 0, errors = 0;
  int m_sp = 'h08FF, m_pc = 0, m_pop = 0;

  always #5 clk = ~clk;

  stack_seq u_stack_seq (
    .clk(clk), .rst_n(rst_n), .wide_pc(wide_pc), .req_valid(req_valid), .req_op(req_op),
    .pc_in(pc_in), .target_in(target_in), .zptr_in(zptr_in), .ext_in(ext_in),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sp_out(sp_out), .pc_out(pc_out), .pop_data(pop_data),
    .set_ie(set_ie), .done(done));

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic run(input int op, input int pc, input int tgt, input int z,
                     input int ext, input bit noise, input string req);
    int n, ret, newpc, val, off;
    int ea[3];
    int ed[3];
    bit wr;
    n   = (op >= 6) ? 1 : (wide_pc ? 3 : 2);
    wr  = (op <= 3) || (op == 6);
    ret = (pc + ((op == 0) ? 2 : 1)) & 'h3FFFFF;
    off = (tgt & 'h800) ? (tgt & 'hFFF) - 4096 : (tgt & 'hFFF);
    case (op)
      0: newpc = tgt;
      1: newpc = pc + 1 + off;
      2: newpc = z;
      3: newpc = (ext << 16) | z;
      default: newpc = m_pc;
    endcase
    val = 0;
    for (int k = 0; k < n; k++) begin
      if (wr) begin
        ea[k] = m_sp;
        ed[k] = (op == 6) ? ext : ((ret >> (8 * k)) & 'hFF);
        m_sp = (m_sp - 1) & 'hFFFF;
      end else begin
        m_sp = (m_sp + 1) & 'hFFFF;
        ea[k] = m_sp;
        val = (val << 8) | int'(mem[m_sp & 'hFF]);
      end
    end
    if (op <= 3) m_pc = newpc & 'hFFFF;
    if (op == 4 || op == 5) m_pc = val & 'hFFFF;
    if (op == 7) m_pop = val & 'hFF;

    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); pc_in = 22'(pc); target_in = 22'(tgt);
    zptr_in = 16'(z); ext_in = 8'(ext);
    @(negedge clk);
    req_valid = noise; req_op = 3'd7; ext_in = 8'h5A;
    for (int k = 0; k < n; k++) begin
      chk({req, " we"}, int'(mem_we), int'(wr));
      chk({req, " re"}, int'(mem_re), int'(!wr));
      chk({req, " addr"}, int'(mem_addr), ea[k]);
      if (wr) chk({req, " wdata"}, int'(mem_wdata), ed[k]);
      chk("R12 no early done", int'(done), 0);
      if (k < n - 1) @(negedge clk);
    end
    @(negedge clk);
    chk("R12 done after last access", int'(done), 1);
    chk("R12 no strobe at done", int'(mem_we | mem_re), 0);
    chk({req, " sp"}, int'(sp_out), m_sp);
    chk({req, " pc R10"}, int'(pc_out), m_pc);
    chk("R6 set_ie", int'(set_ie), int'(op == 5));
    if (op == 7) chk({req, " pop_data"}, int'(pop_data), m_pop);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12 done single cycle", int'(done), 0);
    chk("R11 idle after sequence", int'(mem_we | mem_re | set_ie), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 sp reset", int'(sp_out), 'h08FF);
    chk("R1 pc reset", int'(pc_out), 0);
    chk("R1 strobes reset", int'(mem_we | mem_re | done | set_ie), 0);
    rst_n = 1'b1;
    run(6, 0, 0, 0, 'hA5, 0, "R2 push");
    run(6, 0, 0, 0, 'h3C, 0, "R2 push");
    run(7, 0, 0, 0, 0, 0, "R3 pop");
    run(7, 0, 0, 0, 0, 0, "R3 pop");
    run(0, 'h1234, 'h00ABCD, 0, 0, 0, "R9 direct call R4");
    run(4, 0, 0, 0, 0, 0, "R5 return");
    run(1, 'h0100, 'hFFE, 0, 0, 0, "R7 relative back");
    run(1, 'hFF00, 'h7FF, 0, 0, 0, "R7 relative fwd R10");
    run(2, 'h0400, 0, 'hBEEF, 0, 0, "R8 indirect");
    run(3, 'h0500, 0, 'h1111, 'h03, 0, "R8 extended");
    run(5, 0, 0, 0, 0, 0, "R6 reti");
    run(4, 0, 0, 0, 0, 0, "R5 return");
    run(4, 0, 0, 0, 0, 0, "R5 return");
    run(0, 'h0777, 'h002222, 0, 0, 1, "R11 busy call");
    run(4, 0, 0, 0, 0, 0, "R11 return after busy");
    wide_pc = 1'b1;
    run(0, 'h2FFFE, 'h3F0001, 0, 0, 0, "R4 wide call R9");
    run(2, 'h12345, 0, 'h4321, 0, 0, "R4 wide indirect");
    run(4, 0, 0, 0, 0, 0, "R5 wide return");
    run(5, 0, 0, 0, 0, 0, "R6 wide reti R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule